// File: doc/BRIEF.md
# DMA Interrupt Pending Aggregator

This block collects the completion events of every channel of a multi-channel DMA controller and turns them into a small set of interrupt lines. Each channel keeps a sticky event status word and an interrupt-control mask. The status bits are set by one-cycle pulses from the transfer engines. Software clears them by writing a mask.

When the masked status of a channel turns nonzero, that channel's bit is raised in four independent global pending words, one per interrupt bank. Each bank also has its own global enable word. Bank b drives interrupt line b. That line is the registered OR over all channels of pending AND enable. Pending bits are cleared by writing ones. A separate read-only word reports which channels are idle.

Software reaches every word through a plain read/write register port. Read data is registered. All other pins are plain control or status levels with no handshake.

Top module: `dma_irq_merge`

## Requirements
- R1: An event pulse on `ev_in[n*5+k]` sets bit k of channel n's status word, and the bit stays set until software clears it. The bit meanings are: 0 block done, 1 whole chain done, 2 frame done, 3 half frame, 4 last frame.
- R2: Channel n's status word is at byte address 0x100*(n+1)+0x44. A write there clears each status bit whose `bus_wdata` bit is 1 (the low 8 bits act as the mask; only bits 0 to 4 exist). An event arriving in the same cycle as the clear keeps its bit set.
- R3: Channel n's interrupt-control mask is at 0x100*(n+1)+0x40. It has 5 bits laid out like the status word. It reads back what was written, and data bits above bit 4 are dropped.
- R4: When (mask AND status) of channel n changes from zero to nonzero, bit n of all four pending words sets on the next clock edge. A nonzero masked status that simply persists does not set the bit again after it has been cleared.
- R5: Pending word b is at 0x00+4*b. Writing it clears exactly the bits written as 1 and leaves the other bits and the other banks unchanged. A read issued in the cycle after the clearing write returns the cleared value.
- R6: When a pending bit's set condition and its write-one clear fall on the same edge, the bit ends up set.
- R7: Enable word b is at 0x10+4*b. It holds one bit per channel and reads back what was written.
- R8: `irq_out[b]` is the registered OR over channels of (pending b AND enable b). It follows a change of pending or enable by one clock cycle.
- R9: The word at 0x2C reads bit n as 1 while `ch_busy[n]` is 0.
- R10: After reset, all status, mask, pending and enable bits are 0, `irq_out` is 0 and `bus_rdata` is 0. Reads of unmapped addresses, including channel banks beyond the last channel, return 0.
- R11: `bus_rdata` updates on the clock edge that samples `bus_rd` high and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_in | input | 20 | Event pulses, 5 per channel, channel n in bits n*5+4..n*5 |
| ch_busy | input | 4 | Channel active flags from the transfer engines |
| irq_out | output | 4 | Banked interrupt lines |

## Verification
The bench goes after the edge cases where a set condition and a clear meet.

- A design in which the clear beats a new event would lose an interrupt. This happens either when the event lands in the same cycle as the pending clear, or when it lands in the same cycle as the status clear.
- A level-triggered pending bit would re-raise itself right after software clears it while the status is still set.
- A pending bit that ignores a mask opened late would never fire when software enables an event that is already recorded.
- Bank isolation is checked by clearing one bank and reading the others. A shared pending word would wipe them all.
- Reading one cycle after each clear catches a read path that returns stale data.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int EV_W = 5;
  localparam int OFS_PEND = 'h00;
  localparam int OFS_EN   = 'h10;
  localparam int OFS_IDLE = 'h2C;
  localparam int OFS_CTL  = 'h40;
  localparam int OFS_STAT = 'h44;
  localparam int BANK_SPAN = 'h100;
endpackage

// File: rtl/irq_chan_evt.sv
module irq_chan_evt
  import dma_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  input  logic            ctl_we,
  input  logic            stat_we,
  input  logic [EV_W-1:0] wmask,
  output logic [EV_W-1:0] ctl,
  output logic [EV_W-1:0] stat,
  output logic            rise
);
  logic gated, gated_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      stat    <= '0;
      gated_q <= 1'b0;
    end else begin
      if (ctl_we) ctl <= wmask;
      stat    <= (stat & ~(stat_we ? wmask : '0)) | ev;
      gated_q <= gated;
    end
  end

  assign gated = |(ctl & stat);
  assign rise  = gated & ~gated_q;

  p_ev_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((stat & $past(ev)) == $past(ev)));
  p_stat_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((stat & $past(stat)) == $past(stat)));
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl));
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_in,
  input  logic           pend_we,
  input  logic           en_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] en,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~(pend_we ? wdata : '0)) | set_in;
      if (en_we) en <= wdata;
      irq  <= |(pend & en);
    end
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_in) |=> ((pend & $past(set_in)) == $past(set_in)));
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && (set_in == '0)) |=> ((pend & $past(wdata)) == '0));
  p_irq_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en)) |=> irq);
  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & en)) |=> !irq);
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NBANK  = 4,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NUM_CH*EV_W-1:0] ev_in,
  input  logic [NUM_CH-1:0]      ch_busy,
  output logic [NBANK-1:0]       irq_out
);
  localparam int RW = AW - 8;

  logic [RW-1:0]     region;
  logic [7:0]        lo;
  logic [EV_W-1:0]   ctl_a [NUM_CH];
  logic [EV_W-1:0]   stat_a[NUM_CH];
  logic [NUM_CH-1:0] rise_v;
  logic [NUM_CH-1:0] pend_a[NBANK];
  logic [NUM_CH-1:0] en_a  [NBANK];
  logic [DW-1:0]     rdata_n;
  logic              unused_wbits;

  assign region       = bus_addr[AW-1:8];
  assign lo           = bus_addr[7:0];
  assign unused_wbits = ^bus_wdata;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic sel;
    assign sel = (region == RW'(n + 1));
    irq_chan_evt i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev_in[n*EV_W +: EV_W]),
      .ctl_we  (bus_wr && sel && (int'(lo) == OFS_CTL)),
      .stat_we (bus_wr && sel && (int'(lo) == OFS_STAT)),
      .wmask   (bus_wdata[EV_W-1:0]),
      .ctl     (ctl_a[n]),
      .stat    (stat_a[n]),
      .rise    (rise_v[n])
    );
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_bank #(.NCH(NUM_CH)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_in  (rise_v),
      .pend_we (bus_wr && (region == '0) && (int'(lo) == OFS_PEND + 4*b)),
      .en_we   (bus_wr && (region == '0) && (int'(lo) == OFS_EN + 4*b)),
      .wdata   (bus_wdata[NUM_CH-1:0]),
      .pend    (pend_a[b]),
      .en      (en_a[b]),
      .irq     (irq_out[b])
    );
  end

  always_comb begin
    rdata_n = '0;
    if (region == '0) begin
      for (int b = 0; b < NBANK; b++) begin
        if (int'(lo) == OFS_PEND + 4*b) rdata_n[NUM_CH-1:0] = pend_a[b];
        if (int'(lo) == OFS_EN + 4*b)   rdata_n[NUM_CH-1:0] = en_a[b];
      end
      if (int'(lo) == OFS_IDLE) rdata_n[NUM_CH-1:0] = ~ch_busy;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (region == RW'(n + 1)) begin
          if (int'(lo) == OFS_CTL)  rdata_n[EV_W-1:0] = ctl_a[n];
          if (int'(lo) == OFS_STAT) rdata_n[EV_W-1:0] = stat_a[n];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_n;
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_dma_irq_merge.sv
`timescale 1ns/1ps
module test_dma_irq_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [19:0] ev_in = '0;
  logic [3:0]  ch_busy = 4'b0101;
  logic [3:0]  irq_out;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  dma_irq_merge i_dma_irq_merge (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_in(ev_in), .ch_busy(ch_busy), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ch_addr(int n, int ofs);
    return 12'(32'h100 * (n + 1) + ofs);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int ch, logic [4:0] bits);
    @(negedge clk);
    ev_in[ch*5 +: 5] = bits;
    @(negedge clk);
    ev_in = '0;
    @(negedge clk);
  endtask

  // scoreboard monitor: read result appears after the edge that sampled bus_rd
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    idle(3);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 irq after reset", 32'(irq_out), 0);
    check("R10 rdata after reset", bus_rdata, 0);
    rd(12'h000, 0, "R10 pend0 reset");
    rd(12'h010, 0, "R10 en0 reset");
    rd(ch_addr(1, 'h44), 0, "R10 stat1 reset");
    // R9 idle word
    rd(12'h02C, 32'hA, "R9 idle");
    // R3 control mask
    wr(ch_addr(1, 'h40), 32'h1F);
    rd(ch_addr(1, 'h40), 32'h1F, "R3 ctl1 readback");
    wr(ch_addr(1, 'h40), 32'hFF);
    rd(ch_addr(1, 'h40), 32'h1F, "R3 ctl1 upper bits dropped");
    // R1 frame-done event on ch1
    pulse(1, 5'h04);
    rd(ch_addr(1, 'h44), 32'h04, "R1 stat1 frame bit");
    rd(12'h000, 32'h2, "R4 pend0 after ch1 event");
    rd(12'h00C, 32'h2, "R4 pend3 after ch1 event");
    // R8 interrupt line
    wr(12'h010, 32'h2);
    idle(1);
    check("R8 irq after en0", 32'(irq_out), 32'h1);
    // R5 write-one clear, read in the very next cycle
    wr(12'h00C, 32'h0);
    wr(12'h000, 32'h2);
    rd(12'h000, 32'h0, "R5 pend0 read right after clear");
    rd(12'h004, 32'h2, "R5 pend1 untouched");
    rd(12'h00C, 32'h2, "R5 pend3 zero write no effect");
    check("R8 irq drops after clear", 32'(irq_out), 0);
    // R4 no re-set while status persists
    idle(3);
    rd(12'h000, 32'h0, "R4 pend0 not re-raised");
    // R2 status clear then new event
    wr(ch_addr(1, 'h44), 32'h04);
    rd(ch_addr(1, 'h44), 32'h0, "R2 stat1 cleared");
    pulse(1, 5'h01);
    rd(12'h000, 32'h2, "R4 pend0 after new ch1 event");
    // R4 late mask opening
    pulse(2, 5'h08);
    rd(12'h000, 32'h2, "R4 masked ch2 does not pend");
    wr(ch_addr(2, 'h40), 32'h08);
    idle(1);
    rd(12'h000, 32'h6, "R4 pend after mask opened");
    // R6 set and clear on the same edge
    wr(ch_addr(3, 'h40), 32'h10);
    @(negedge clk);
    ev_in[15 +: 5] = 5'h10;
    @(negedge clk);
    ev_in = '0;
    bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'hE;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(12'h000, 32'h8, "R6 set wins over clear");
    rd(12'h008, 32'hE, "R6 other bank collects all");
    // R2 event wins over status clear
    pulse(0, 5'h01);
    @(negedge clk);
    ev_in[0 +: 5] = 5'h01;
    bus_wr = 1'b1; bus_addr = ch_addr(0, 'h44); bus_wdata = 32'h01;
    @(negedge clk);
    bus_wr = 1'b0; ev_in = '0;
    rd(ch_addr(0, 'h44), 32'h01, "R2 event beats status clear");
    wr(ch_addr(0, 'h44), 32'hFF);
    rd(ch_addr(0, 'h44), 32'h0, "R2 full mask clears");
    // R7 enable word and R8 routing
    wr(12'h018, 32'hF);
    rd(12'h018, 32'hF, "R7 en2 readback");
    check("R8 irq bank2 only", 32'(irq_out), 32'h4);
    // R10 unmapped reads, R11 hold
    rd(12'h030, 32'h0, "R10 unmapped global");
    rd(12'h544, 32'h0, "R10 bank beyond channels");
    rd(12'h02C, 32'hA, "R9 idle again");
    idle(1);
    held = bus_rdata;
    ch_busy = 4'b0000;
    idle(3);
    check("R11 rdata holds without read", bus_rdata, held);
    rd(12'h02C, 32'hF, "R9 idle all");
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule